// File: doc/BRIEF.md
# On-die termination enable timer

This block produces the single termination enable that switches the on-die termination of every data-side pad (data, strobe and its complement, read strobe pair and data mask) on and off together. It follows a termination request pin with a delay that depends on the device's power state. With the device active or in standby it uses a short turn-on and turn-off delay. With the device in power-down it uses a longer pair. Transitions that overlap power-down entry or exit choose between the two pairs using an entry window and an exit window. During self refresh, termination is held off.

The block also captures a 2-bit termination value from an extended mode register write. It keeps that value until the register is written again. When the value selects "disabled", the enable stays low whatever the request pin does. Every delay is a parameter counted in clock cycles. The analog resistor network is outside the block and is driven by `term_en` and `rtt_sel`.

Top module: `odt_term_ctrl`

## Requirements
- R1: After a synchronous reset, `term_en` is 0 and `rtt_sel` is 2'b00.
- R2: A clock edge with `emr1_wr` high loads `{emr1_a6, emr1_a2}` into `rtt_sel`, visible right after that edge. The encoding is 00 = disabled, 01 = 75 ohm, 10 = 150 ohm and 11 = 50 ohm. Without a write, `rtt_sel` holds its value even when the address bits change.
- R3: While `rtt_sel` is 00, `term_en` stays 0 whatever the level of `odt_pin`.
- R4: Suppose a change of `odt_pin` is first sampled at edge k, with `pd_mode` low and no exit window open. Then `term_en` takes the new level at edge k+T_AOND for a rise and at edge k+T_AOFD for a fall (defaults 2 and 2).
- R5: A change first sampled while `pd_mode` is high takes effect at edge k+T_AONPD for a rise and k+T_AOFPD for a fall (defaults 3 and 3).
- R6: Suppose a change is still pending and `pd_mode` is sampled high at an edge fewer than T_ANPD edges after edge k. Then the power-down delay applies, counted from edge k.
- R7: A change first sampled at the edge where `pd_mode` is first seen low uses the power-down delays. The same holds for a change sampled within the following T_AXPD-1 edges (default T_AXPD = 8). Changes sampled later use the active delays.
- R8: When `odt_pin` changes again before a pending change completes, the pending change is discarded and only the newest level is applied, with its own full delay.
- R9: At an edge with `self_ref` high, `term_en` goes low and any pending change is dropped. If `odt_pin` is high when `self_ref` is first sampled low, the block treats it as a new rise.
- R10: Raising `pd_mode` after a change has completed leaves `term_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| odt_pin | input | 1 | Termination request pin |
| pd_mode | input | 1 | Device is in power-down (clock enable low) |
| self_ref | input | 1 | Device is in self refresh |
| emr1_wr | input | 1 | Extended mode register 1 write strobe |
| emr1_a6 | input | 1 | Upper termination select address bit |
| emr1_a2 | input | 1 | Lower termination select address bit |
| term_en | output | 1 | Termination enable shared by all data-side pads |
| rtt_sel | output | 2 | Selected termination value code |

## Verification
The timing function is tried with rises and falls, with power-down held either low or high across the change. Measuring the number of edges until `term_en` follows separates the active delays from the power-down delays, and the turn-on path from the turn-off path. Further patterns raise power-down one edge after a change, and toggle the pin inside and after the exit window. These show whether the entry window and the exit window choose the delay pair. A quick rise-then-fall pulse shows that a replaced transition never reaches the output. Self refresh with the pin held high shows the forced-off level and the fresh rise afterwards. Writes of every code, and address changes without a write, cover capture and retention of the value.

// File: rtl/odt_term_pkg.sv
package odt_term_pkg;

  typedef enum logic [1:0] {
    RTT_OFF = 2'b00,
    RTT_75  = 2'b01,
    RTT_150 = 2'b10,
    RTT_50  = 2'b11
  } rtt_code_e;

  // Pick the delay for a pending transition from its direction and timing class.
  function automatic int unsigned pick_delay(
    input logic        slow,
    input logic        turn_on,
    input int unsigned on_fast,
    input int unsigned off_fast,
    input int unsigned on_slow,
    input int unsigned off_slow
  );
    if (slow) return turn_on ? on_slow : off_slow;
    else      return turn_on ? on_fast : off_fast;
  endfunction

endpackage

// File: rtl/odt_rtt_reg.sv
module odt_rtt_reg
  import odt_term_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  logic      a6,
  input  logic      a2,
  output rtt_code_e code_q,
  output logic      rtt_on
);

  always_ff @(posedge clk) begin
    if (rst)     code_q <= RTT_OFF;
    else if (wr) code_q <= rtt_code_e'({a6, a2});
  end

  assign rtt_on = (code_q != RTT_OFF);

endmodule

// File: rtl/odt_pd_track.sv
module odt_pd_track #(
  parameter int unsigned T_AXPD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pd,
  output logic slow_zone
);

  localparam int unsigned XW = (T_AXPD < 2) ? 1 : $clog2(T_AXPD + 1);

  logic [XW-1:0] xcnt_q;

  // Counter reloads while in power-down and drains after exit.
  always_ff @(posedge clk) begin
    if (rst)                 xcnt_q <= '0;
    else if (pd)             xcnt_q <= XW'(T_AXPD);
    else if (xcnt_q != '0)   xcnt_q <= xcnt_q - XW'(1);
  end

  assign slow_zone = pd | (xcnt_q != '0);

endmodule

// File: rtl/odt_delay_timer.sv
module odt_delay_timer
  import odt_term_pkg::*;
#(
  parameter int unsigned T_AOND  = 2,
  parameter int unsigned T_AOFD  = 2,
  parameter int unsigned T_AONPD = 3,
  parameter int unsigned T_AOFPD = 3,
  parameter int unsigned T_ANPD  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic pd,
  input  logic sr,
  input  logic slow_zone,
  output logic raw_en
);

  localparam int unsigned MAX_A = (T_AOND > T_AOFD) ? T_AOND : T_AOFD;
  localparam int unsigned MAX_B = (T_AONPD > T_AOFPD) ? T_AONPD : T_AOFPD;
  localparam int unsigned MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned AW    = $clog2(MAXD + 1) + 1;

  logic          pin_q, pend_q, tgt_q, slow_q, raw_q;
  logic [AW-1:0] age_q;
  int unsigned   age_i, dly;
  logic          toggle, eff_slow, fire;

  assign age_i    = 32'(age_q);
  assign toggle   = (pin != pin_q);
  // Entering power-down early in the window moves the pending change to slow timing.
  assign eff_slow = slow_q | (pd & (age_i < T_ANPD));
  assign dly      = pick_delay(eff_slow, tgt_q, T_AOND, T_AOFD, T_AONPD, T_AOFPD);
  assign fire     = pend_q & (age_i >= dly);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
      slow_q <= 1'b0;
      raw_q  <= 1'b0;
      age_q  <= '0;
    end else if (sr) begin
      pin_q  <= 1'b0;
      pend_q <= 1'b0;
      slow_q <= 1'b0;
      raw_q  <= 1'b0;
      age_q  <= '0;
    end else begin
      pin_q <= pin;
      if (toggle) begin
        pend_q <= 1'b1;
        tgt_q  <= pin;
        age_q  <= AW'(1);
        slow_q <= slow_zone;
      end else if (pend_q) begin
        if (fire) begin
          raw_q  <= tgt_q;
          pend_q <= 1'b0;
        end else begin
          age_q  <= age_q + AW'(1);
          slow_q <= eff_slow;
        end
      end
    end
  end

  assign raw_en = raw_q;

endmodule

// File: rtl/odt_term_ctrl.sv
module odt_term_ctrl
  import odt_term_pkg::*;
#(
  parameter int unsigned T_AOND  = 2,
  parameter int unsigned T_AOFD  = 2,
  parameter int unsigned T_AONPD = 3,
  parameter int unsigned T_AOFPD = 3,
  parameter int unsigned T_ANPD  = 3,
  parameter int unsigned T_AXPD  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       odt_pin,
  input  logic       pd_mode,
  input  logic       self_ref,
  input  logic       emr1_wr,
  input  logic       emr1_a6,
  input  logic       emr1_a2,
  output logic       term_en,
  output logic [1:0] rtt_sel
);

  rtt_code_e code;
  logic      rtt_on, slow_zone, raw_en;

  odt_rtt_reg u_rtt (
    .clk(clk), .rst(rst), .wr(emr1_wr), .a6(emr1_a6), .a2(emr1_a2),
    .code_q(code), .rtt_on(rtt_on)
  );

  odt_pd_track #(.T_AXPD(T_AXPD)) u_pd (
    .clk(clk), .rst(rst), .pd(pd_mode), .slow_zone(slow_zone)
  );

  odt_delay_timer #(
    .T_AOND(T_AOND), .T_AOFD(T_AOFD), .T_AONPD(T_AONPD),
    .T_AOFPD(T_AOFPD), .T_ANPD(T_ANPD)
  ) u_tmr (
    .clk(clk), .rst(rst), .pin(odt_pin), .pd(pd_mode), .sr(self_ref),
    .slow_zone(slow_zone), .raw_en(raw_en)
  );

  assign term_en = raw_en & rtt_on;
  assign rtt_sel = code;

endmodule

// File: rtl/odt_term_chk.sv
module odt_term_chk (
  input logic       clk,
  input logic       rst,
  input logic       self_ref,
  input logic       emr1_wr,
  input logic       emr1_a6,
  input logic       emr1_a2,
  input logic       term_en,
  input logic [1:0] rtt_sel
);

  AST_SR_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    self_ref |=> !term_en);  // R9

  AST_SR_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(term_en) |-> !$past(self_ref));  // R9

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    (rtt_sel == 2'b00) |-> !term_en);  // R3

  AST_RTT_LOAD: assert property (@(posedge clk) disable iff (rst)
    emr1_wr |=> (rtt_sel == $past({emr1_a6, emr1_a2})));  // R2

  AST_RTT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !emr1_wr |=> $stable(rtt_sel));  // R2

endmodule

bind odt_term_ctrl odt_term_chk u_chk (
  .clk(clk), .rst(rst), .self_ref(self_ref), .emr1_wr(emr1_wr),
  .emr1_a6(emr1_a6), .emr1_a2(emr1_a2), .term_en(term_en), .rtt_sel(rtt_sel)
);

// File: tb/sim_odt_term_ctrl.sv
`timescale 1ns/1ps
module sim_odt_term_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       odt_pin = 1'b0, pd_mode = 1'b0, self_ref = 1'b0;
  logic       emr1_wr = 1'b0, emr1_a6 = 1'b0, emr1_a2 = 1'b0;
  logic       term_en;
  logic [1:0] rtt_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  odt_term_ctrl u0 (
    .clk(clk), .rst(rst), .odt_pin(odt_pin), .pd_mode(pd_mode),
    .self_ref(self_ref), .emr1_wr(emr1_wr), .emr1_a6(emr1_a6),
    .emr1_a2(emr1_a2), .term_en(term_en), .rtt_sel(rtt_sel)
  );

  // {pd held, target level, expected edges to follow}
  localparam logic [5:0] VEC [4] = '{
    {1'b0, 1'b1, 4'd2},   // R4 rise, active
    {1'b0, 1'b0, 4'd2},   // R4 fall, active
    {1'b1, 1'b1, 4'd3},   // R5 rise, power-down
    {1'b1, 1'b0, 4'd3}    // R5 fall, power-down
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input logic lvl);
    @(negedge clk);
    odt_pin = lvl;
    pd_mode = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  // Edges counted from the edge that first samples the pin change.
  task automatic measure(input logic tgt, input int pd_step, input logic pd_val, output int n);
    n = -1;
    for (int i = 1; i <= 14; i++) begin
      @(posedge clk); #1;
      if (n < 0 && term_en == tgt) n = i - 1;
      if (i == pd_step) pd_mode = pd_val;
    end
  endtask

  task automatic wr_rtt(input logic [1:0] code);
    @(negedge clk);
    emr1_wr = 1'b1; {emr1_a6, emr1_a2} = code;
    @(negedge clk);
    emr1_wr = 1'b0;
    chk(rtt_sel == code, "R2 load", rtt_sel, code);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(term_en == 1'b0, "R1 term_en", term_en, 0);
    chk(rtt_sel == 2'b00, "R1 rtt_sel", rtt_sel, 0);

    // R3: disabled value keeps termination off
    settle(1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(term_en == 1'b0, "R3 disabled", term_en, 0);
    end

    // R2: all codes, then hold without write
    wr_rtt(2'b01);
    wr_rtt(2'b10);
    wr_rtt(2'b11);
    chk(term_en == 1'b1, "R3 enable after non-zero code", term_en, 1);
    @(negedge clk); {emr1_a6, emr1_a2} = 2'b00;
    repeat (3) @(negedge clk);
    chk(rtt_sel == 2'b11, "R2 hold", rtt_sel, 3);

    // Table of steady-mode delays
    for (int v = 0; v < 4; v++) begin
      settle(~VEC[v][4]);
      if (VEC[v][5]) begin
        pd_mode = 1'b1;
        repeat (2) @(negedge clk);
      end
      odt_pin = VEC[v][4];
      measure(VEC[v][4], 0, 1'b0, n);
      chk(n == int'(VEC[v][3:0]), VEC[v][5] ? "R5 delay" : "R4 delay", n, VEC[v][3:0]);
    end

    // R6: power-down entered one edge after the change
    settle(1'b0);
    odt_pin = 1'b1;
    measure(1'b1, 1, 1'b1, n);
    chk(n == 3, "R6 entry window", n, 3);

    // R10: power-down after completion leaves the enable unchanged
    settle(1'b1);
    pd_mode = 1'b1;
    repeat (5) @(negedge clk);
    chk(term_en == 1'b1, "R10 late entry", term_en, 1);

    // R7: change inside exit window
    settle(1'b0);
    pd_mode = 1'b1;
    repeat (5) @(negedge clk);
    pd_mode = 1'b0;
    repeat (2) @(negedge clk);
    odt_pin = 1'b1;
    measure(1'b1, 0, 1'b0, n);
    chk(n == 3, "R7 inside exit window", n, 3);

    // R7: change after exit window
    settle(1'b0);
    pd_mode = 1'b1;
    repeat (5) @(negedge clk);
    pd_mode = 1'b0;
    repeat (10) @(negedge clk);
    odt_pin = 1'b1;
    measure(1'b1, 0, 1'b0, n);
    chk(n == 2, "R7 after exit window", n, 2);

    // R8: short pulse is replaced and never appears
    settle(1'b0);
    odt_pin = 1'b1;
    @(negedge clk);
    odt_pin = 1'b0;
    n = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (term_en) n++;
    end
    chk(n == 0, "R8 replaced pulse", n, 0);
    odt_pin = 1'b1;
    @(negedge clk);
    odt_pin = 1'b0;
    @(negedge clk);
    odt_pin = 1'b1;
    measure(1'b1, 0, 1'b0, n);
    chk(n == 2, "R8 newest level", n, 2);

    // R9: self refresh forces off, fresh rise afterwards
    @(negedge clk);
    chk(term_en == 1'b1, "R9 pre-check", term_en, 1);
    self_ref = 1'b1;
    @(posedge clk); #1;
    chk(term_en == 1'b0, "R9 forced off", term_en, 0);
    repeat (3) @(negedge clk);
    chk(term_en == 1'b0, "R9 held off", term_en, 0);
    self_ref = 1'b0;
    measure(1'b1, 0, 1'b0, n);
    chk(n == 2, "R9 rise after exit", n, 2);

    chk(rtt_sel == 2'b11, "R2 retained", rtt_sel, 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule